// File: doc/BRIEF.md
# Tagged Multi-History Branch Direction Predictor

The block predicts whether a conditional branch is taken. It holds five direction tables. Table 0 is untagged and indexed by branch address bits alone, so it always has an answer. Tables 1 to 4 are tagged, and each one looks at a longer slice of the global outcome history: table t uses the newest t*HSTEP history bits. For every table, the index is the address XORed with a folded copy of that table's history slice. The tag comes from the address bits just above the index field, XORed with the slice folded to the tag width. A lookup returns the prediction from the tagged table with the longest history whose valid entry matches the tag. If no tagged table matches, the prediction comes from table 0.

The lookup port is combinational. It returns the direction, the number of the table that gave it, and the indices it computed for all five tables. The front end keeps the table number and the indices. When the branch resolves, it sends them back on the update port with the actual outcome. An update trains the counter of the providing entry only. A misprediction by any table other than table 4 also claims one entry in the next longer table. Every update shifts the outcome into the global history. Tags for a new entry are computed from the history at the time of the update. For that reason an update belongs to the lookup made just before it, with no other update in between.

Top module: `hist_pred`

## Requirements
- R1: Reset clears every tagged entry's valid bit and sets every counter to weakly not-taken (2^(CTR_W-1)-1). The history is cleared. After reset, any lookup returns provider 0 and not-taken.
- R2: The table-0 index is lk_pc[IDX_W-1:0]. The table-t index (t = 1..4) is lk_pc[IDX_W-1:0] XOR the fold of history bits [t*HSTEP-1:0], where history bit i is XORed into index bit (i mod IDX_W). lk_idx carries the table-t index at bits [t*IDX_W +: IDX_W].
- R3: The tag for table t is lk_pc[IDX_W+TAG_W-1:IDX_W] XOR the fold of the same history slice into TAG_W bits, using the same bit-mapping rule. A tagged table hits only when its entry is valid and its stored tag equals this value.
- R4: lk_prov is the highest table number, as a plain binary value 0..4, that hits. It is 0 when no tagged table hits.
- R5: lk_taken is the most significant bit of the providing entry's counter.
- R6: An update moves the counter at up_idx for table up_prov one step toward up_taken, saturating at 0 and 2^CTR_W-1. No other counter is trained.
- R7: An update whose provider counter MSB differs from up_taken, with up_prov below 4, writes into table up_prov+1 at its up_idx slot. The entry becomes valid, takes the tag for that table computed from up_pc and the current history, and gets counter 2^(CTR_W-1) for taken or 2^(CTR_W-1)-1 for not-taken.
- R8: A misprediction by table 4 allocates nothing. A correct prediction allocates nothing.
- R9: Each update shifts up_taken into history bit 0, and older bits move up one place. With up_valid low, the history holds.
- R10: A lookup changes no state. With no update, repeated lookups of the same address give the same result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Branch address to look up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_prov | output | 3 | Number of the providing table (0..4) |
| lk_idx | output | 5*IDX_W | Index computed for each table, table t at [t*IDX_W +: IDX_W] |
| up_valid | input | 1 | Update strobe |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome |
| up_prov | input | 3 | Providing table returned by the lookup |
| up_idx | input | 5*IDX_W | Indices returned by the lookup |

## Verification
The bench builds the block with PC_W=12, IDX_W=4, TAG_W=4, CTR_W=3 and HSTEP=2. With these values the longest history slice is 8 bits, twice the index width, so the fold wraps and its mapping is tested. With 16-entry tables, tag matches and aliasing happen within a few hundred branches. The 3-bit counters reach both saturation limits. A phase that drives provider numbers and indices directly sends updates to table 4 and to every allocation target, including mispredictions by the longest table.

// File: rtl/hp_pkg.sv
package hp_pkg;

    localparam int NUM_TBL = 5;

    typedef logic [2:0] tbl_id_t;

    // XOR the lowest len bits of v onto w output bit positions, bit i landing on bit i mod w.
    function automatic logic [31:0] fold_bits(input logic [31:0] v, input int len, input int w);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < len) r[i % w] = r[i % w] ^ v[i];
        end
        return r;
    endfunction

    // Saturating step of a w-bit counter toward the given direction.
    function automatic logic [31:0] ctr_step(input logic [31:0] c, input logic up, input int w);
        logic [31:0] top;
        top = (32'd1 << w) - 32'd1;
        if (up) return (c == top) ? c : c + 32'd1;
        return (c == 32'd0) ? c : c - 32'd1;
    endfunction

endpackage

// File: rtl/hp_hash.sv
module hp_hash import hp_pkg::*; #(
    parameter int PC_W   = 16,
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 6,
    parameter int HIST_W = 4,
    parameter int HLEN   = 0
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    logic [31:0] hist_w;
    logic        unused_pc_bits;

    assign hist_w         = 32'(hist);
    assign idx            = pc[IDX_W-1:0] ^ IDX_W'(fold_bits(hist_w, HLEN, IDX_W));
    assign tag            = pc[IDX_W+TAG_W-1:IDX_W] ^ TAG_W'(fold_bits(hist_w, HLEN, TAG_W));
    assign unused_pc_bits = ^pc;
endmodule

// File: rtl/hp_table.sv
module hp_table #(
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 6,
    parameter int CTR_W  = 2,
    parameter bit TAGGED = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [CTR_W-1:0] lk_ctr,
    input  logic [IDX_W-1:0] up_idx,
    output logic [CTR_W-1:0] up_ctr,
    input  logic             train_en,
    input  logic [CTR_W-1:0] train_val,
    input  logic             alloc_en,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic [CTR_W-1:0] alloc_ctr
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CTR_W-1:0] WEAK_NT = CTR_W'((1 << (CTR_W - 1)) - 1);

    logic [CTR_W-1:0] ctr_q [DEPTH];

    assign lk_ctr = ctr_q[lk_idx];
    assign up_ctr = ctr_q[up_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= WEAK_NT;
        end else if (alloc_en) begin
            ctr_q[up_idx] <= alloc_ctr;
        end else if (train_en) begin
            ctr_q[up_idx] <= train_val;
        end
    end

    generate
        if (TAGGED) begin : g_tagged
            logic             vld_q [DEPTH];
            logic [TAG_W-1:0] tag_q [DEPTH];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        vld_q[i] <= 1'b0;
                        tag_q[i] <= '0;
                    end
                end else if (alloc_en) begin
                    vld_q[up_idx] <= 1'b1;
                    tag_q[up_idx] <= alloc_tag;
                end
            end

            assign lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        end else begin : g_base
            logic unused_tag_bits;
            assign unused_tag_bits = ^{lk_tag, alloc_tag};
            assign lk_hit = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/hist_pred.sv
module hist_pred import hp_pkg::*; #(
    parameter int PC_W  = 16,
    parameter int IDX_W = 6,
    parameter int TAG_W = 6,
    parameter int CTR_W = 2,
    parameter int HSTEP = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [PC_W-1:0]          lk_pc,
    output logic                     lk_taken,
    output logic [2:0]               lk_prov,
    output logic [NUM_TBL*IDX_W-1:0] lk_idx,
    input  logic                     up_valid,
    input  logic [PC_W-1:0]          up_pc,
    input  logic                     up_taken,
    input  logic [2:0]               up_prov,
    input  logic [NUM_TBL*IDX_W-1:0] up_idx
);
    localparam int HIST_W = (NUM_TBL - 1) * HSTEP;
    localparam logic [CTR_W-1:0] WEAK_T = CTR_W'(1 << (CTR_W - 1));

    typedef struct packed {
        logic    taken;
        tbl_id_t prov;
    } lk_res_t;

    logic [HIST_W-1:0] ghr_q;
    logic [NUM_TBL-1:0] hit, train_en, alloc_en;
    logic [CTR_W-1:0]  rd_ctr   [NUM_TBL];
    logic [CTR_W-1:0]  up_ctr   [NUM_TBL];
    logic [IDX_W-1:0]  lk_ix    [NUM_TBL];
    logic [TAG_W-1:0]  lk_tag   [NUM_TBL];
    logic [TAG_W-1:0]  up_tag   [NUM_TBL];
    logic [IDX_W-1:0]  unused_up_ix [NUM_TBL];
    logic [CTR_W-1:0]  sel_ctr, train_val, weak_ctr;
    logic              prov_ok, mispred;
    lk_res_t           res;

    generate
        for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
            hp_hash #(
                .PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
                .HIST_W(HIST_W), .HLEN(t * HSTEP)
            ) u_lk_hash (
                .pc(lk_pc), .hist(ghr_q), .idx(lk_ix[t]), .tag(lk_tag[t])
            );

            hp_hash #(
                .PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
                .HIST_W(HIST_W), .HLEN(t * HSTEP)
            ) u_up_hash (
                .pc(up_pc), .hist(ghr_q), .idx(unused_up_ix[t]), .tag(up_tag[t])
            );

            hp_table #(
                .IDX_W(IDX_W), .TAG_W(TAG_W), .CTR_W(CTR_W), .TAGGED(t != 0)
            ) u_tbl (
                .clk       (clk),
                .rst       (rst),
                .lk_idx    (lk_ix[t]),
                .lk_tag    (lk_tag[t]),
                .lk_hit    (hit[t]),
                .lk_ctr    (rd_ctr[t]),
                .up_idx    (up_idx[t*IDX_W +: IDX_W]),
                .up_ctr    (up_ctr[t]),
                .train_en  (train_en[t]),
                .train_val (train_val),
                .alloc_en  (alloc_en[t]),
                .alloc_tag (up_tag[t]),
                .alloc_ctr (weak_ctr)
            );

            assign lk_idx[t*IDX_W +: IDX_W] = lk_ix[t];
        end
    endgenerate

    // Longest matching history wins; table 0 always hits.
    always_comb begin
        res = '0;
        for (int t = 0; t < NUM_TBL; t++) begin
            if (hit[t]) res.prov = tbl_id_t'(t);
        end
        for (int t = 0; t < NUM_TBL; t++) begin
            if (res.prov == tbl_id_t'(t)) res.taken = rd_ctr[t][CTR_W-1];
        end
    end

    assign lk_taken = res.taken;
    assign lk_prov  = res.prov;

    // Update: train the provider, claim one entry one table further on a miss.
    always_comb begin
        sel_ctr = '0;
        prov_ok = 1'b0;
        for (int t = 0; t < NUM_TBL; t++) begin
            if (up_prov == tbl_id_t'(t)) begin
                sel_ctr = up_ctr[t];
                prov_ok = 1'b1;
            end
        end
        mispred   = sel_ctr[CTR_W-1] != up_taken;
        train_val = CTR_W'(ctr_step(32'(sel_ctr), up_taken, CTR_W));
        weak_ctr  = up_taken ? WEAK_T : WEAK_T - CTR_W'(1);
        for (int t = 0; t < NUM_TBL; t++) begin
            train_en[t] = up_valid && prov_ok && (up_prov == tbl_id_t'(t));
            alloc_en[t] = up_valid && prov_ok && mispred && (int'(up_prov) + 1 == t);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           ghr_q <= '0;
        else if (up_valid) ghr_q <= {ghr_q[HIST_W-2:0], up_taken};
    end
endmodule

// File: rtl/hp_chk.sv
module hp_chk #(
    parameter int PC_W   = 16,
    parameter int HIST_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [PC_W-1:0]   lk_pc,
    input logic              lk_taken,
    input logic [2:0]        lk_prov,
    input logic              up_valid,
    input logic              up_taken,
    input logic [HIST_W-1:0] ghr
);
    // R4
    prov_range_chk: assert property (@(posedge clk) disable iff (rst)
        lk_prov <= 3'd4);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (lk_prov == 3'd0 && !lk_taken));

    // R9
    hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
        up_valid |=> (ghr[0] == $past(up_taken)));

    // R9
    hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !up_valid |=> $stable(ghr));

    // R10
    lookup_pure_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!up_valid) && $stable(lk_pc)) |-> ($stable(lk_taken) && $stable(lk_prov)));
endmodule

bind hist_pred hp_chk #(.PC_W(PC_W), .HIST_W(HIST_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lk_pc    (lk_pc),
    .lk_taken (lk_taken),
    .lk_prov  (lk_prov),
    .up_valid (up_valid),
    .up_taken (up_taken),
    .ghr      (ghr_q)
);

// File: tb/sim_hist_pred.sv
module sim_hist_pred;
    localparam int PC_W  = 12;
    localparam int IDX_W = 4;
    localparam int TAG_W = 4;
    localparam int CTR_W = 3;
    localparam int HSTEP = 2;
    localparam int NT    = 5;
    localparam int DEPTH = 1 << IDX_W;
    localparam int HMASK = (1 << (4 * HSTEP)) - 1;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [PC_W-1:0]     lk_pc = '0;
    logic                lk_taken;
    logic [2:0]          lk_prov;
    logic [NT*IDX_W-1:0] lk_idx;
    logic                up_valid = 1'b0;
    logic [PC_W-1:0]     up_pc = '0;
    logic                up_taken = 1'b0;
    logic [2:0]          up_prov = '0;
    logic [NT*IDX_W-1:0] up_idx = '0;

    always #5 clk = ~clk;

    hist_pred #(
        .PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .CTR_W(CTR_W), .HSTEP(HSTEP)
    ) u0 (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .lk_prov(lk_prov), .lk_idx(lk_idx), .up_valid(up_valid),
        .up_pc(up_pc), .up_taken(up_taken), .up_prov(up_prov), .up_idx(up_idx)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Behavioural reference state.
    int mctr [NT][DEPTH];
    bit mval [NT][DEPTH];
    int mtag [NT][DEPTH];
    int mghr;
    int midx [NT];
    int uix  [NT];
    int mprov;
    int mtaken;

    function automatic int fold(int v, int len, int w);
        int r = 0;
        for (int i = 0; i < len; i++) if (((v >> i) & 1) != 0) r = r ^ (1 << (i % w));
        return r;
    endfunction

    function automatic int seg(int t);
        return mghr & ((1 << (t * HSTEP)) - 1);
    endfunction

    function automatic int m_index(int t, int pc);
        return (pc & (DEPTH - 1)) ^ fold(seg(t), t * HSTEP, IDX_W);
    endfunction

    function automatic int m_tag(int t, int pc);
        return ((pc >> IDX_W) & ((1 << TAG_W) - 1)) ^ fold(seg(t), t * HSTEP, TAG_W);
    endfunction

    task automatic m_reset();
        for (int t = 0; t < NT; t++)
            for (int i = 0; i < DEPTH; i++) begin
                mctr[t][i] = (1 << (CTR_W - 1)) - 1;
                mval[t][i] = 1'b0;
                mtag[t][i] = 0;
            end
        mghr = 0;
    endtask

    task automatic m_lookup(int pc);
        for (int t = 0; t < NT; t++) midx[t] = m_index(t, pc);
        mprov = 0;
        for (int t = 1; t < NT; t++)
            if (mval[t][midx[t]] && mtag[t][midx[t]] == m_tag(t, pc)) mprov = t;
        mtaken = (mctr[mprov][midx[mprov]] >> (CTR_W - 1)) & 1;
    endtask

    task automatic m_update(int pc, int tk, int prov);
        int c, pred, top;
        top = (1 << CTR_W) - 1;
        c = mctr[prov][uix[prov]];
        pred = (c >> (CTR_W - 1)) & 1;
        if (tk != 0) c = (c == top) ? c : c + 1;
        else         c = (c == 0) ? 0 : c - 1;
        mctr[prov][uix[prov]] = c;
        if (pred != tk && prov < NT - 1) begin
            mval[prov+1][uix[prov+1]] = 1'b1;
            mtag[prov+1][uix[prov+1]] = m_tag(prov + 1, pc);
            mctr[prov+1][uix[prov+1]] = (tk != 0) ? (1 << (CTR_W - 1)) : (1 << (CTR_W - 1)) - 1;
        end
        mghr = ((mghr << 1) | tk) & HMASK;
    endtask

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d (time %0t)", req, act, exp, $time);
        end
    endtask

    // One cycle: look up pc, compare, optionally update with the outcome.
    task automatic step(int pc, bit do_up, int tk, bit forced);
        logic [NT*IDX_W-1:0] eidx;
        int prov;
        @(negedge clk);
        lk_pc = PC_W'(pc);
        #1;
        m_lookup(pc);
        eidx = '0;
        for (int t = 0; t < NT; t++) eidx[t*IDX_W +: IDX_W] = IDX_W'(midx[t]);
        // R5 R6: direction from provider counter after training
        check("R5 R6 direction", int'(lk_taken), mtaken);
        // R4 R3 R7 R8: provider from tag hits after allocation
        check("R4 R3 R7 R8 provider", int'(lk_prov), mprov);
        // R2 R9: indices depend on shifted history
        check("R2 R9 indices", int'(lk_idx), int'(eidx));
        if (do_up) begin
            if (forced) begin
                prov = $urandom_range(NT - 1);
                for (int t = 0; t < NT; t++) uix[t] = $urandom_range(DEPTH - 1);
            end else begin
                prov = mprov;
                for (int t = 0; t < NT; t++) uix[t] = midx[t];
            end
            up_pc = PC_W'(pc);
            up_taken = tk[0];
            up_prov = 3'(prov);
            for (int t = 0; t < NT; t++) up_idx[t*IDX_W +: IDX_W] = IDX_W'(uix[t]);
            up_valid = 1'b1;
        end
        @(posedge clk);
        #1;
        if (do_up) begin
            m_update(pc, tk, prov);
            up_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int pcs [6];
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: after reset every lookup is provider 0, not taken
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            lk_pc = PC_W'(i * 331);
            #1;
            check("R1 reset provider", int'(lk_prov), 0);
            check("R1 reset direction", int'(lk_taken), 0);
        end

        // R6: one address always taken walks counters to saturation
        for (int i = 0; i < 30; i++) step(12'h3a5, 1'b1, 1, 1'b0);

        // Loop-style branch: taken seven times then falls through
        for (int r = 0; r < 20; r++)
            for (int i = 0; i < 8; i++) step(12'h5c0, 1'b1, (i < 7) ? 1 : 0, 1'b0);

        // Alternating branch needs history to be predicted
        for (int i = 0; i < 60; i++) step(12'h1e7, 1'b1, i % 2, 1'b0);

        // Mix of addresses with random outcomes
        pcs[0] = 12'h010; pcs[1] = 12'h2f3; pcs[2] = 12'h7a1;
        pcs[3] = 12'h4c8; pcs[4] = 12'h93d; pcs[5] = 12'hb06;
        for (int i = 0; i < 300; i++)
            step(pcs[$urandom_range(5)], 1'b1, $urandom_range(1), 1'b0);

        // R7 R8: provider numbers and slots driven directly, table 4 included
        for (int i = 0; i < 200; i++)
            step(pcs[$urandom_range(5)], 1'b1, $urandom_range(1), 1'b1);

        // R10: lookups alone change nothing
        for (int i = 0; i < 20; i++) step(pcs[i % 6], 1'b0, 0, 1'b0);

        // R6: saturation toward not-taken on the same address
        for (int i = 0; i < 30; i++) step(12'h3a5, 1'b1, 0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule